// File: doc/BRIEF.md
# UART Host Register File with Identification Readback

This block is the processor-facing register set of a single-channel UART that follows the common 550-style layout. A host drives a 3-bit address with write and read strobes. The block stores the control registers: line control, FIFO control, interrupt enable, modem control, scratchpad and the two divisor bytes. It multiplexes stored values and incoming status onto the read data bus. It also produces the interrupt pin from the occupancy counts of the transmit and receive FIFOs, which are supplied as inputs. The serial shifters, the baud generator, the FIFO storage and flow control live elsewhere. This block only presents their status and passes the programmed values to them.

A two-state bank machine tracks the divisor-access bit of the line control register. Its states are BANK_DATA and BANK_DIVISOR. The OPEN_DIVISOR transition is taken on a line-control write with bit 7 set, and the CLOSE_DIVISOR transition on a line-control write with bit 7 clear. In BANK_DIVISOR, addresses 0 and 1 reach the divisor bytes. If both divisor bytes hold zero, reads of those addresses return a fixed identification code and revision code instead of the stored bytes.

Top module: `uart_rf_top`

## Requirements
- R1: After reset, interrupt enable, line control, modem control, scratchpad, both divisor bytes and FIFO control are zero, the bank is BANK_DATA, `int_o` is low, and an address-2 read returns 0x01.
- R2: Writing address 3 with bit 7 set enters BANK_DIVISOR; with bit 7 clear it returns to BANK_DATA; in BANK_DIVISOR a write to address 0 gives no `tx_wr_o` pulse and a read of address 1 returns the high divisor byte instead of interrupt enable.
- R3: In BANK_DIVISOR, address 0 holds the low divisor byte and address 1 the high byte; when at least one of them is non-zero both read back as stored, and `divisor_o` equals {high, low}.
- R4: In BANK_DIVISOR with both divisor bytes zero, address 1 reads the identification code 0x01 and address 0 reads the revision code 0x01.
- R5: In BANK_DATA, a write to address 0 asserts `tx_wr_o` for that cycle with `tx_data_o` equal to the write data; a read of address 0 returns `rx_data_i` and asserts `rx_rd_o`.
- R6: Interrupt enable (address 1, bits 3:0 stored, bits 7:4 read zero), line control (address 3, all 8 bits), modem control (address 4) and scratchpad (address 7) read back what was written.
- R7: FIFO control bit 3 may be written as 0 or 1 and changes neither `int_o` nor the address-2 read value.
- R8: With FIFO control bit 0 clear, the transmit condition is true exactly when `tx_count_i` is zero.
- R9: With FIFO control bit 0 set, the transmit condition is true when `tx_count_i` is below the transmit level chosen by bits 5:4: 00 gives 1, 01 gives DEPTH/4, 10 gives DEPTH/2, 11 gives 3*DEPTH/4.
- R10: With FIFO control bit 0 clear, the receive condition is true exactly when `rx_count_i` is non-zero.
- R11: With FIFO control bit 0 set, the receive condition is true when `rx_count_i` is at or above the receive level chosen by bits 7:6: 00 gives 1, 01 gives DEPTH/4, 10 gives DEPTH/2, 11 gives DEPTH-2.
- R12: `int_o` = (IER bit 0 and receive condition) or (IER bit 1 and transmit condition). The address-2 read returns bits 7:6 = 11 when FIFOs are enabled (otherwise 00), bits 5:3 = 0, and bits 2:0 = 100 if the enabled receive condition holds, else 010 if the enabled transmit condition holds, else 001.
- R13: Address 5 reads `line_status_i` and address 6 reads `modem_status_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational on addr) |
| rx_data_i | input | 8 | Byte at the head of the receive FIFO |
| line_status_i | input | 8 | Line status byte |
| modem_status_i | input | 8 | Modem status byte |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| tx_wr_o | output | 1 | Push strobe to the transmit FIFO |
| tx_data_o | output | 8 | Byte pushed to the transmit FIFO |
| rx_rd_o | output | 1 | Pop strobe to the receive FIFO |
| lcr_o | output | 8 | Line control value |
| mcr_o | output | 8 | Modem control value |
| divisor_o | output | 16 | Divisor {high, low} |
| fifo_en_o | output | 1 | FIFO enable bit |
| int_o | output | 1 | Interrupt pin |

## Verification
The receive and transmit interrupt conditions can both be true in the same cycle. This is provoked by sweeping both occupancy counts together through every value from 0 to DEPTH, for every trigger selection, FIFO mode and enable mask. The pin must be the OR of the two enabled conditions, and the status read must report the receive source over the transmit source. Each FIFO control write also carries the no-effect bit together with the mode and trigger bits. This checks that a change to that bit in the same write never moves the pin or the status value.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    typedef enum logic {
        BANK_DATA    = 1'b0,
        BANK_DIVISOR = 1'b1
    } bank_e;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_IER  = 3'd1;
    localparam logic [2:0] A_ISR  = 3'd2;
    localparam logic [2:0] A_LCR  = 3'd3;
    localparam logic [2:0] A_MCR  = 3'd4;
    localparam logic [2:0] A_LSR  = 3'd5;
    localparam logic [2:0] A_MSR  = 3'd6;
    localparam logic [2:0] A_SPR  = 3'd7;

    // Receive threshold: count at or above this raises the condition.
    function automatic int rx_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

    // Transmit threshold: count below this raises the condition.
    function automatic int tx_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return (depth * 3) / 4;
        endcase
    endfunction

endpackage

// File: rtl/uart_rf_bank_fsm.sv
module uart_rf_bank_fsm
    import uart_rf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lcr_wr,
    input  logic  sel_divisor,
    output bank_e state_o
);

    bank_e state_q;
    bank_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BANK_DATA;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_DATA: begin
                // OPEN_DIVISOR
                if (lcr_wr && sel_divisor) begin
                    state_d = BANK_DIVISOR;
                end
            end
            BANK_DIVISOR: begin
                // CLOSE_DIVISOR
                if (lcr_wr && !sel_divisor) begin
                    state_d = BANK_DATA;
                end
            end
            default: state_d = BANK_DATA;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/uart_rf_regs.sv
module uart_rf_regs
    import uart_rf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    input  bank_e      bank,
    output logic [3:0] ier_o,
    output logic       fifo_en_o,
    output logic [1:0] rx_sel_o,
    output logic [1:0] tx_sel_o,
    output logic [6:0] lcr_low_o,
    output logic [7:0] mcr_o,
    output logic [7:0] spr_o,
    output logic [7:0] dll_o,
    output logic [7:0] dlm_o,
    output logic       tx_wr_o,
    output logic       lcr_wr_o
);

    logic in_div;
    logic wr_low;
    logic wr_high;

    assign in_div   = (bank == BANK_DIVISOR);
    assign wr_low   = wr_en && (addr == A_DATA);
    assign wr_high  = wr_en && (addr == A_IER);
    assign tx_wr_o  = wr_low && !in_div;
    assign lcr_wr_o = wr_en && (addr == A_LCR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_o     <= '0;
            fifo_en_o <= 1'b0;
            rx_sel_o  <= '0;
            tx_sel_o  <= '0;
            lcr_low_o <= '0;
            mcr_o     <= '0;
            spr_o     <= '0;
            dll_o     <= '0;
            dlm_o     <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_DATA: if (in_div) dll_o <= wdata;
                A_IER: begin
                    if (in_div) dlm_o <= wdata;
                    else        ier_o <= wdata[3:0];
                end
                A_ISR: begin
                    // Bit 3 (block-transfer mode) and the flush bits are accepted and dropped.
                    fifo_en_o <= wdata[0];
                    tx_sel_o  <= wdata[5:4];
                    rx_sel_o  <= wdata[7:6];
                end
                A_LCR:  lcr_low_o <= wdata[6:0];
                A_MCR:  mcr_o     <= wdata;
                A_SPR:  spr_o     <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
    import uart_rf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             fifo_en,
    input  logic [1:0]       rx_sel,
    input  logic [1:0]       tx_sel,
    input  logic [1:0]       ier_src,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    output logic             int_o,
    output logic [7:0]       isr_o
);

    localparam int LVL_W = CNT_W + 1;

    logic [LVL_W-1:0] rx_lvl;
    logic [LVL_W-1:0] tx_lvl;
    logic             rx_cond;
    logic             tx_cond;
    logic             rx_pend;
    logic             tx_pend;

    always_comb begin
        rx_lvl = LVL_W'(rx_level(rx_sel, DEPTH));
        tx_lvl = LVL_W'(tx_level(tx_sel, DEPTH));
        if (fifo_en) begin
            rx_cond = ({1'b0, rx_count} >= rx_lvl);
            tx_cond = ({1'b0, tx_count} <  tx_lvl);
        end else begin
            rx_cond = (rx_count != '0);
            tx_cond = (tx_count == '0);
        end
        rx_pend = rx_cond && ier_src[0];
        tx_pend = tx_cond && ier_src[1];
        int_o   = rx_pend || tx_pend;

        isr_o      = 8'h00;
        isr_o[7:6] = {fifo_en, fifo_en};
        if (rx_pend)      isr_o[2:0] = 3'b100;
        else if (tx_pend) isr_o[2:0] = 3'b010;
        else              isr_o[2:0] = 3'b001;
    end

endmodule

// File: rtl/uart_rf_top.sv
module uart_rf_top
    import uart_rf_pkg::*;
#(
    parameter int         DEPTH    = 16,
    parameter logic [7:0] DEV_ID   = 8'h01,
    parameter logic [7:0] REV_CODE = 8'h01,
    parameter int         CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [7:0]       rx_data_i,
    input  logic [7:0]       line_status_i,
    input  logic [7:0]       modem_status_i,
    input  logic [CNT_W-1:0] tx_count_i,
    input  logic [CNT_W-1:0] rx_count_i,
    output logic             tx_wr_o,
    output logic [7:0]       tx_data_o,
    output logic             rx_rd_o,
    output logic [7:0]       lcr_o,
    output logic [7:0]       mcr_o,
    output logic [15:0]      divisor_o,
    output logic             fifo_en_o,
    output logic             int_o
);

    bank_e      bank;
    logic       dlab;
    logic       lcr_wr;
    logic [3:0] ier_q;
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic [6:0] lcr_low;
    logic [7:0] spr_q;
    logic [7:0] dll_q;
    logic [7:0] dlm_q;
    logic [7:0] isr;
    logic       id_mode;

    uart_rf_bank_fsm u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .lcr_wr      (lcr_wr),
        .sel_divisor (wdata[7]),
        .state_o     (bank)
    );

    uart_rf_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .bank      (bank),
        .ier_o     (ier_q),
        .fifo_en_o (fifo_en_o),
        .rx_sel_o  (rx_sel),
        .tx_sel_o  (tx_sel),
        .lcr_low_o (lcr_low),
        .mcr_o     (mcr_o),
        .spr_o     (spr_q),
        .dll_o     (dll_q),
        .dlm_o     (dlm_q),
        .tx_wr_o   (tx_wr_o),
        .lcr_wr_o  (lcr_wr)
    );

    uart_rf_irq #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_irq (
        .fifo_en  (fifo_en_o),
        .rx_sel   (rx_sel),
        .tx_sel   (tx_sel),
        .ier_src  (ier_q[1:0]),
        .tx_count (tx_count_i),
        .rx_count (rx_count_i),
        .int_o    (int_o),
        .isr_o    (isr)
    );

    assign dlab      = (bank == BANK_DIVISOR);
    assign lcr_o     = {dlab, lcr_low};
    assign divisor_o = {dlm_q, dll_q};
    assign tx_data_o = wdata;
    assign rx_rd_o   = rd_en && (addr == A_DATA) && !dlab;
    assign id_mode   = (dll_q == 8'h00) && (dlm_q == 8'h00);

    always_comb begin
        unique case (addr)
            A_DATA:  rdata = dlab ? (id_mode ? REV_CODE : dll_q) : rx_data_i;
            A_IER:   rdata = dlab ? (id_mode ? DEV_ID : dlm_q) : {4'b0000, ier_q};
            A_ISR:   rdata = isr;
            A_LCR:   rdata = lcr_o;
            A_MCR:   rdata = mcr_o;
            A_LSR:   rdata = line_status_i;
            A_MSR:   rdata = modem_status_i;
            default: rdata = spr_q;
        endcase
    end

endmodule

// File: rtl/uart_rf_checker.sv
module uart_rf_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       addr,
    input logic             wr_en,
    input logic [7:0]       wdata,
    input logic             dlab,
    input logic [3:0]       ier,
    input logic             fifo_en,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_wr,
    input logic             int_o
);

    assert_bank_follows_lcr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd3) |=> (dlab == $past(wdata[7])));

    assert_thr_push_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0) |-> (tx_wr == !dlab));

    assert_tx_empty_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && tx_count == '0 && ier[1]) |-> int_o);

    assert_rx_byte_raises_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rx_count != '0 && ier[0]) |-> int_o);

    assert_masked_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[1:0] == 2'b00) |-> !int_o);

endmodule

bind uart_rf_top uart_rf_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .dlab     (dlab),
    .ier      (ier_q),
    .fifo_en  (fifo_en_o),
    .tx_count (tx_count_i),
    .rx_count (rx_count_i),
    .tx_wr    (tx_wr_o),
    .int_o    (int_o)
);

// File: tb/tb_uart_rf_top.sv
module tb_uart_rf_top;

    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       addr = '0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [7:0]       wdata = '0;
    logic [7:0]       rdata;
    logic [7:0]       rx_data_i = '0;
    logic [7:0]       line_status_i = '0;
    logic [7:0]       modem_status_i = '0;
    logic [CNT_W-1:0] tx_count_i = '0;
    logic [CNT_W-1:0] rx_count_i = '0;
    logic             tx_wr_o;
    logic [7:0]       tx_data_o;
    logic             rx_rd_o;
    logic [7:0]       lcr_o;
    logic [7:0]       mcr_o;
    logic [15:0]      divisor_o;
    logic             fifo_en_o;
    logic             int_o;

    int  n_checks = 0;
    int  n_fails = 0;
    logic seen_push;
    logic [7:0] seen_data;

    always #2 clk = ~clk;

    uart_rf_top dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_data_i(rx_data_i),
        .line_status_i(line_status_i), .modem_status_i(modem_status_i),
        .tx_count_i(tx_count_i), .rx_count_i(rx_count_i), .tx_wr_o(tx_wr_o),
        .tx_data_o(tx_data_o), .rx_rd_o(rx_rd_o), .lcr_o(lcr_o), .mcr_o(mcr_o),
        .divisor_o(divisor_o), .fifo_en_o(fifo_en_o), .int_o(int_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        #1;
        seen_push = tx_wr_o;
        seen_data = tx_data_o;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic pop);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        pop = rx_rd_o;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic int rx_lvl(input int s);
        if (s == 0) return 1;
        if (s == 1) return DEPTH / 4;
        if (s == 2) return DEPTH / 2;
        return DEPTH - 2;
    endfunction

    function automatic int tx_lvl(input int s);
        if (s == 0) return 1;
        if (s == 1) return DEPTH / 4;
        if (s == 2) return DEPTH / 2;
        return (DEPTH * 3) / 4;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic       p;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 int_o", 16'(int_o), 16'h0);
        check("R1 divisor_o", divisor_o, 16'h0000);
        check("R1 lcr_o", 16'(lcr_o), 16'h00);
        check("R1 mcr_o", 16'(mcr_o), 16'h00);
        check("R1 fifo_en_o", 16'(fifo_en_o), 16'h0);
        rd(3'd1, d, p); check("R1 ier", 16'(d), 16'h00);
        rd(3'd2, d, p); check("R1 isr", 16'(d), 16'h01);
        rd(3'd7, d, p); check("R1 spr", 16'(d), 16'h00);

        // R6 readback
        wr(3'd1, 8'hAB); rd(3'd1, d, p); check("R6 ier", 16'(d), 16'h0B);
        wr(3'd4, 8'h5A); rd(3'd4, d, p); check("R6 mcr", 16'(d), 16'h5A);
        wr(3'd7, 8'hC3); rd(3'd7, d, p); check("R6 spr", 16'(d), 16'hC3);
        wr(3'd3, 8'h1B); rd(3'd3, d, p); check("R6 lcr", 16'(d), 16'h1B);
        wr(3'd1, 8'h00);

        // R2 and R4: open divisor bank with zero divisor
        wr(3'd3, 8'h83);
        check("R2 lcr_o bank bit", 16'(lcr_o[7]), 16'h1);
        wr(3'd0, 8'h00);
        check("R2 no push in divisor bank", 16'(seen_push), 16'h0);
        wr(3'd1, 8'h00);
        rd(3'd1, d, p); check("R4 device id", 16'(d), 16'h01);
        rd(3'd0, d, p); check("R4 revision", 16'(d), 16'h01);
        check("R2 no pop in divisor bank", 16'(p), 16'h0);

        // R3 stored readback once non-zero
        wr(3'd0, 8'h34);
        rd(3'd0, d, p); check("R3 low byte", 16'(d), 16'h34);
        rd(3'd1, d, p); check("R3 high byte zero", 16'(d), 16'h00);
        wr(3'd1, 8'h12);
        rd(3'd1, d, p); check("R3 high byte", 16'(d), 16'h12);
        check("R3 divisor_o", divisor_o, 16'h1234);
        wr(3'd0, 8'h00);
        rd(3'd0, d, p); check("R3 low zero stored", 16'(d), 16'h00);
        rd(3'd1, d, p); check("R3 high with low zero", 16'(d), 16'h12);
        wr(3'd1, 8'h00);
        rd(3'd1, d, p); check("R4 id after re-zero", 16'(d), 16'h01);

        // R2 close bank, interrupt enable visible again
        wr(3'd1, 8'h07);
        wr(3'd3, 8'h03);
        check("R2 lcr_o bank bit clear", 16'(lcr_o[7]), 16'h0);
        rd(3'd1, d, p); check("R2 ier after close", 16'(d), 16'h00);
        @(negedge clk);
        addr = 3'd3; #1;
        check("R2 divisor kept", divisor_o, 16'h0700);

        // R5 transmit push and receive pop
        wr(3'd0, 8'h77);
        check("R5 push strobe", 16'(seen_push), 16'h1);
        check("R5 push data", 16'(seen_data), 16'h77);
        rx_data_i = 8'h9C;
        rd(3'd0, d, p);
        check("R5 rx data", 16'(d), 16'h9C);
        check("R5 pop strobe", 16'(p), 16'h1);

        // R13 status pass-through
        line_status_i = 8'h61; modem_status_i = 8'hB0;
        rd(3'd5, d, p); check("R13 line status", 16'(d), 16'h61);
        rd(3'd6, d, p); check("R13 modem status", 16'(d), 16'hB0);

        // R7..R12 sweep
        for (int fe = 0; fe < 2; fe++) begin
            for (int rs = 0; rs < 4; rs++) begin
                for (int ts = 0; ts < 4; ts++) begin
                    for (int dm = 0; dm < 2; dm++) begin
                        wr(3'd2, 8'(rs * 64 + ts * 16 + dm * 8 + fe));
                        for (int ie = 0; ie < 4; ie++) begin
                            wr(3'd1, 8'(ie));
                            for (int t = 0; t <= DEPTH; t++) begin
                                for (int r = 0; r <= DEPTH; r++) begin
                                    logic txc, rxc, rp, tp;
                                    logic [7:0] eisr;
                                    string tag;
                                    @(negedge clk);
                                    tx_count_i = CNT_W'(t);
                                    rx_count_i = CNT_W'(r);
                                    addr = 3'd2;
                                    #1;
                                    if (fe != 0) begin
                                        txc = (t < tx_lvl(ts));
                                        rxc = (r >= rx_lvl(rs));
                                        tag = "R9 R11 R12";
                                    end else begin
                                        txc = (t == 0);
                                        rxc = (r != 0);
                                        tag = "R8 R10 R12";
                                    end
                                    if (dm != 0) tag = {tag, " R7"};
                                    rp = rxc && (ie % 2 == 1);
                                    tp = txc && (ie >= 2);
                                    eisr = (fe != 0) ? 8'hC0 : 8'h00;
                                    if (rp)      eisr[2:0] = 3'b100;
                                    else if (tp) eisr[2:0] = 3'b010;
                                    else         eisr[2:0] = 3'b001;
                                    check({tag, " int_o"}, 16'(int_o), 16'(rp || tp));
                                    check({tag, " isr"}, 16'(rdata), 16'(eisr));
                                end
                            end
                        end
                    end
                end
            end
        end

        finish_run();
    end

endmodule